// File: doc/BRIEF.md
# Extended-State Restore Mask Unit

This block decides, for one restore of a processor's extended register state, what happens to each of 63 state components. Each component is either loaded from the save area, reset to its initial value, or left unchanged. The caller gives four 64-bit words on one handshake: the mask carried by the instruction, the enabled-feature control register, the header's presence bitmap and the header's format word. One cycle later the block returns a load vector and an init vector. It also returns strobes that tell the data path to load the SSE control/status register, or to set that register to 0x1F80. The block keeps the in-use bitmap and the modified bitmap that later save operations consult. It does not move any data, raise any fault or access memory.

The request side is a valid/ready pair. A request is taken on a cycle where `start_valid` and `start_ready` are both high. `start_ready` is low for exactly the one cycle in which `done` is high. A request offered in that cycle is dropped, so the caller has to hold it or offer it again. The result side has no back-pressure. The data path must consume the two strobes in the `done` cycle. The load and init vectors keep their values until the next request is accepted.

Top module: `xsr_mask_unit`

## Requirements
- R1: The requested set is `instr_mask AND feat_en`. Any component whose requested bit is 0 ends with 0 in both `load_vec` and `init_vec`.
- R2: Bit 63 of `hdr_format` selects the form: 0 is standard, 1 is compacted.
- R3: In standard form, `load_vec = req AND hdr_present` and `init_vec = req AND NOT hdr_present`.
- R4: In compacted form, let fmt be `hdr_format` with bit 63 cleared. Then `load_vec = req AND hdr_present AND fmt` and `init_vec = (req AND NOT hdr_present) OR (req AND NOT fmt)`.
- R5: In standard form, `csr_load` pulses when req bit 1 or req bit 2 is set, even if bit 1 is clear. `csr_init` stays 0.
- R6: In compacted form, `csr_load` pulses exactly when `load_vec[1]` is set. `csr_init`, which asks for the value 0x1F80, pulses exactly when `init_vec[1]` is set.
- R7: After a restore, `inuse` bits whose component was loaded are 1 and bits whose component was initialized are 0. All other `inuse` bits keep their previous value.
- R8: After a restore, `modified` equals NOT req over all 64 bits.
- R9: Results appear and `done` pulses high for one cycle in the cycle after acceptance. `start_ready` is low during that cycle. A request offered then produces no `done` and leaves all outputs unchanged.
- R10: Bit 63 of `load_vec` and of `init_vec` is always 0.
- R11: After reset, every output vector and strobe is 0 and `start_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_valid | input | 1 | Restore request offered |
| start_ready | output | 1 | Request can be taken this cycle |
| instr_mask | input | 64 | Mask carried by the instruction |
| feat_en | input | 64 | Enabled-feature control register |
| hdr_present | input | 64 | Header bitmap of components present in the area |
| hdr_format | input | 64 | Header format word; bit 63 selects compacted form |
| load_vec | output | 64 | Components to load from memory |
| init_vec | output | 64 | Components to reset to initial values |
| csr_load | output | 1 | Load the SSE control/status register (one-cycle pulse) |
| csr_init | output | 1 | Set the SSE control/status register to 0x1F80 (one-cycle pulse) |
| done | output | 1 | Result valid, one-cycle pulse |
| inuse | output | 64 | In-use tracking bitmap |
| modified | output | 64 | Modified tracking bitmap |

## Verification
The bench sends standard-form requests with req bit 2 set and req bit 1 clear. A design that ties the control/status load to component 1 alone would miss the `csr_load` pulse there. Compacted requests use format words that leave requested components out. A design without the forced-init term would leave those components unchanged when it should reset them, and it would also fail to raise `csr_init`. Inputs with bit 63 set everywhere catch a design that leaks the form bit into the vectors. Chains of restores with partial masks catch a tracking bitmap that clears bits it should have kept. A request offered during the `done` cycle must not produce a second result.

// File: rtl/xsr_pkg.sv
package xsr_pkg;
  localparam int XW = 64;

  typedef struct packed {
    logic [XW-1:0] load;
    logic [XW-1:0] init;
    logic          csr_load;
    logic          csr_init;
  } xsr_plan_t;
endpackage

// File: rtl/xsr_form_decode.sv
module xsr_form_decode #(
  parameter int W        = xsr_pkg::XW,
  parameter int FORM_BIT = W - 1,
  parameter int SSE_BIT  = 1,
  parameter int WIDE_BIT = 2
) (
  input  logic [W-1:0]      req,
  input  logic [W-1:0]      present,
  input  logic [W-1:0]      format,
  output xsr_pkg::xsr_plan_t plan
);
  localparam logic [W-1:0] COMP_MASK = ~({{(W-1){1'b0}}, 1'b1} << FORM_BIT);

  logic         compact;
  logic [W-1:0] raw_ld;
  logic [W-1:0] raw_in;

  assign compact = format[FORM_BIT];

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic std_ld, std_in, cmp_ld, cmp_in;
    assign std_ld    = req[i] & present[i];
    assign std_in    = req[i] & ~present[i];
    assign cmp_ld    = std_ld & format[i];
    assign cmp_in    = std_in | (req[i] & ~format[i]);
    assign raw_ld[i] = compact ? cmp_ld : std_ld;
    assign raw_in[i] = compact ? cmp_in : std_in;
  end

  always_comb begin
    plan          = '0;
    plan.load     = raw_ld & COMP_MASK;
    plan.init     = raw_in & COMP_MASK;
    plan.csr_load = compact ? raw_ld[SSE_BIT] : (req[SSE_BIT] | req[WIDE_BIT]);
    plan.csr_init = compact & raw_in[SSE_BIT];
  end
endmodule

// File: rtl/xsr_track.sv
module xsr_track #(
  parameter int W = xsr_pkg::XW
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         upd,
  input  logic [W-1:0] load,
  input  logic [W-1:0] init,
  input  logic [W-1:0] req,
  output logic [W-1:0] inuse,
  output logic [W-1:0] modified
);
  for (genvar i = 0; i < W; i++) begin : g_use
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               inuse[i] <= 1'b0;
      else if (upd && load[i])  inuse[i] <= 1'b1;
      else if (upd && init[i])  inuse[i] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   modified <= '0;
    else if (upd) modified <= ~req;
  end
endmodule

// File: rtl/xsr_mask_unit.sv
module xsr_mask_unit #(
  parameter int W        = xsr_pkg::XW,
  parameter int FORM_BIT = W - 1,
  parameter int SSE_BIT  = 1,
  parameter int WIDE_BIT = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_valid,
  output logic         start_ready,
  input  logic [W-1:0] instr_mask,
  input  logic [W-1:0] feat_en,
  input  logic [W-1:0] hdr_present,
  input  logic [W-1:0] hdr_format,
  output logic [W-1:0] load_vec,
  output logic [W-1:0] init_vec,
  output logic         csr_load,
  output logic         csr_init,
  output logic         done,
  output logic [W-1:0] inuse,
  output logic [W-1:0] modified
);
  logic               accept;
  logic [W-1:0]       req;
  xsr_pkg::xsr_plan_t plan;

  assign start_ready = ~done;
  assign accept      = start_valid & start_ready;
  assign req         = instr_mask & feat_en;

  xsr_form_decode #(.W(W), .FORM_BIT(FORM_BIT), .SSE_BIT(SSE_BIT), .WIDE_BIT(WIDE_BIT)) u_dec (
    .req(req), .present(hdr_present), .format(hdr_format), .plan(plan)
  );

  xsr_track #(.W(W)) u_trk (
    .clk(clk), .rst_n(rst_n), .upd(accept), .load(plan.load), .init(plan.init),
    .req(req), .inuse(inuse), .modified(modified)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_vec <= '0;
      init_vec <= '0;
      csr_load <= 1'b0;
      csr_init <= 1'b0;
      done     <= 1'b0;
    end else begin
      done     <= accept;
      csr_load <= accept & plan.csr_load;
      csr_init <= accept & plan.csr_init;
      if (accept) begin
        load_vec <= plan.load;
        init_vec <= plan.init;
      end
    end
  end
endmodule

// File: rtl/xsr_mask_chk.sv
module xsr_mask_chk #(
  parameter int W = 64
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start_valid,
  input logic         start_ready,
  input logic [W-1:0] instr_mask,
  input logic [W-1:0] feat_en,
  input logic [W-1:0] load_vec,
  input logic [W-1:0] init_vec,
  input logic         csr_load,
  input logic         csr_init,
  input logic         done,
  input logic [W-1:0] inuse,
  input logic [W-1:0] modified
);
  AST_UNREQ_UNTOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
    (start_valid && start_ready) |=> (((load_vec | init_vec) & ~($past(instr_mask) & $past(feat_en))) == '0)); // R1
  AST_MOD_IS_NOT_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (start_valid && start_ready) |=> (modified == ~($past(instr_mask) & $past(feat_en)))); // R8
  AST_LOADED_INUSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((inuse & load_vec) == load_vec)); // R7
  AST_INIT_NOT_INUSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((inuse & init_vec) == '0)); // R7
  AST_DONE_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (start_valid && start_ready) |=> done); // R9
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
  AST_STROBES_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_load || csr_init) |-> done); // R9
  AST_TOP_BIT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !load_vec[W-1] && !init_vec[W-1]); // R10
endmodule

bind xsr_mask_unit xsr_mask_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_valid(start_valid), .start_ready(start_ready),
  .instr_mask(instr_mask), .feat_en(feat_en), .load_vec(load_vec), .init_vec(init_vec),
  .csr_load(csr_load), .csr_init(csr_init), .done(done), .inuse(inuse), .modified(modified)
);

// File: tb/sim_xsr_mask_unit.sv
module sim_xsr_mask_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_valid = 1'b0;
  logic        start_ready;
  logic [63:0] instr_mask = '0, feat_en = '0, hdr_present = '0, hdr_format = '0;
  logic [63:0] load_vec, init_vec, inuse, modified;
  logic        csr_load, csr_init, done;

  int n_tests = 0;
  int n_fail  = 0;

  typedef struct {
    logic [63:0] ld, in, use_v, mod;
    logic        cl, ci;
    string       tag;
  } exp_t;

  exp_t        exp_q[$];
  logic [63:0] model_use = '0;
  logic [63:0] last_ld = '0;

  always #5 clk = ~clk;

  xsr_mask_unit u0 (
    .clk(clk), .rst_n(rst_n), .start_valid(start_valid), .start_ready(start_ready),
    .instr_mask(instr_mask), .feat_en(feat_en), .hdr_present(hdr_present), .hdr_format(hdr_format),
    .load_vec(load_vec), .init_vec(init_vec), .csr_load(csr_load), .csr_init(csr_init),
    .done(done), .inuse(inuse), .modified(modified)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic exp_t model(input logic [63:0] im, fe, pr, fm, input string tag);
    exp_t        e;
    logic [63:0] rq, fmt;
    rq = im & fe;
    e.tag = tag;
    if (!fm[63]) begin
      e.ld = rq & pr;
      e.in = rq & ~pr;
      e.cl = rq[1] | rq[2];
      e.ci = 1'b0;
    end else begin
      fmt  = {1'b0, fm[62:0]};
      e.ld = rq & pr & fmt;
      e.in = (rq & ~pr) | (rq & ~fmt);
      e.cl = e.ld[1];
      e.ci = e.in[1];
    end
    e.ld[63] = 1'b0;
    e.in[63] = 1'b0;
    e.use_v  = (model_use & ~e.in) | e.ld;
    e.mod    = ~rq;
    return e;
  endfunction

  task automatic drive(input logic [63:0] im, fe, pr, fm, input string tag);
    exp_t e;
    e = model(im, fe, pr, fm, tag);
    model_use = e.use_v;
    last_ld   = e.ld;
    exp_q.push_back(e);
    @(negedge clk);
    instr_mask = im; feat_en = fe; hdr_present = pr; hdr_format = fm;
    start_valid = 1'b1;
    @(negedge clk);
    start_valid = 1'b0;
  endtask

  always @(negedge clk) begin
    if (rst_n && done) begin
      if (exp_q.size() == 0) begin
        n_tests++; n_fail++;
        $display("FAIL R9 unexpected done actual=1 expected=0");
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk({e.tag, " load_vec"}, load_vec, e.ld);
        chk({e.tag, " init_vec"}, init_vec, e.in);
        chk({e.tag, " csr_load R5/R6"}, {63'd0, csr_load}, {63'd0, e.cl});
        chk({e.tag, " csr_init R5/R6"}, {63'd0, csr_init}, {63'd0, e.ci});
        chk("R7 inuse", inuse, e.use_v);
        chk("R8 modified", modified, e.mod);
        chk("R9 ready low with done", {63'd0, start_ready}, 64'd0);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 load_vec", load_vec, '0);
    chk("R11 init_vec", init_vec, '0);
    chk("R11 inuse", inuse, '0);
    chk("R11 modified", modified, '0);
    chk("R11 strobes", {60'd0, csr_load, csr_init, done, start_ready}, 64'd1);

    // R3 R5 standard, everything requested, half present
    drive('1, 64'h0000_0000_0000_00FF, 64'h0000_0000_0000_00A5, 64'h0, "R3 std");
    // R5 exception: req bit 2 set, bit 1 clear
    drive(64'h0000_0000_0000_0005, '1, 64'h0000_0000_0000_0004, 64'h0, "R5 std bit2 only");
    // R5 neither bit 1 nor bit 2
    drive(64'h0000_0000_0000_0009, '1, '1, 64'h0, "R5 std no sse");
    // R1 feature enable masks instruction mask
    drive(64'h0000_0000_0000_FFFF, 64'h0000_0000_0000_0F0F, 64'h0000_0000_0000_3333, 64'h0, "R1 masked");
    // R4 R6 compacted: component 1 left out of format -> forced init
    drive(64'h0000_0000_0000_00FF, '1, '1, 64'h8000_0000_0000_00F5, "R4 cmp forced");
    // R6 compacted: component 1 loaded
    drive(64'h0000_0000_0000_0003, '1, 64'h0000_0000_0000_0002, 64'h8000_0000_0000_0003, "R6 cmp load1");
    // R6 compacted: component 1 not present -> init
    drive(64'h0000_0000_0000_0006, '1, 64'h0000_0000_0000_0004, 64'h8000_0000_0000_0007, "R6 cmp init1");
    // R2 R10 top bit set everywhere, standard and compacted
    drive('1, '1, '1, 64'h0, "R10 std top");
    drive('1, '1, 64'h8000_0000_0000_0000, '1, "R2 R10 cmp top");
    // R7 partial requests keep untouched inuse bits
    drive(64'h0000_0000_0000_F000, '1, 64'h0000_0000_0000_5000, 64'h0, "R7 partial");

    // R9: request offered while done is high is dropped
    drive(64'h0000_0000_0000_0030, '1, 64'h0000_0000_0000_0010, 64'h0, "R9 first");
    start_valid = 1'b1;
    instr_mask = '1; hdr_present = '1;
    @(negedge clk);
    start_valid = 1'b0;
    chk("R9 dropped request done", {63'd0, done}, 64'd0);
    chk("R9 dropped request load_vec", load_vec, last_ld);
    chk("R9 dropped request inuse", inuse, model_use);

    for (int k = 0; k < 24; k++) begin
      logic [63:0] a, b, c, d;
      a = {$urandom, $urandom};
      b = {$urandom, $urandom};
      c = {$urandom, $urandom};
      d = {$urandom, $urandom};
      drive(a, b, c, d, d[63] ? "R4 rnd" : "R3 rnd");
    end
    repeat (3) @(negedge clk);
    chk("R9 all results seen", exp_q.size(), 64'd0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule